// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This controller decides when a working SRAM array and its shadow nonvolatile array exchange their contents, and it steps each exchange through its two phases. A store first erases the nonvolatile copy and then programs every nonvolatile cell at once from the SRAM. A recall first clears the SRAM and then loads the nonvolatile data into it. The nonvolatile array is never written during a recall. Each phase drives its own strobe toward the array models for a number of clock cycles set by a parameter.

A store or recall can be started in two ways: automatically from a digital supply-good flag, or by a one-cycle software request. When the supply flag falls, an automatic store starts, but only if an accepted SRAM write has occurred since the last completed store or recall. While the supply is low, a recall request is latched. That latch is also set out of reset, so a power-up recall follows. The latched recall runs as soon as the supply is good again. A software store is forced whether or not the SRAM is dirty. It is refused while the supply is low and is abandoned if the supply drops while it runs. A recall always runs to the end.

While any phase is active, `busy` is high. The SRAM port uses `busy` to block accesses and to tri-state its outputs. Requests and write strobes that arrive while `busy` is high are dropped. A low-power standby request is granted only while the sequencer is idle. All pins are plain level or strobe controls. No data flows through the block, so it has no valid/ready stream interface.

Top module: `nv_xfer_sequencer`

## Requirements
- R1: After reset is released with `supply_ok` high, a recall runs without any request: `sram_clear` for CLEAR_CYC cycles, then `nv_load` for XFER_CYC cycles.
- R2: A 1-to-0 transition of `supply_ok` seen while idle starts a store only if the SRAM is dirty. If it is clean, `busy` stays low.
- R3: A one-cycle `sw_store_req` while idle with `supply_ok` high starts a store even when the SRAM is clean. While `supply_ok` is low, the request is ignored.
- R4: A store asserts `nv_erase` for ERASE_CYC consecutive cycles, then `nv_program` for PROG_CYC consecutive cycles, and never asserts `sram_clear` or `nv_load`.
- R5: A recall, including one started by a one-cycle `sw_recall_req` while idle with the supply good, asserts `sram_clear` for CLEAR_CYC cycles, then `nv_load` for XFER_CYC cycles, and never asserts `nv_erase` or `nv_program`.
- R6: Store or recall requests arriving while `busy` is high are ignored and do not start a later operation.
- R7: If `supply_ok` is low during a software-started store, the store is abandoned on the next clock edge: `busy` falls and `nv_program` is never asserted.
- R8: A recall in progress completes with full phase lengths even if `supply_ok` falls during it.
- R9: Any cycle with `supply_ok` low latches a recall request. The recall runs once `supply_ok` is high and the sequencer is idle.
- R10: Completing a store or a recall leaves the SRAM clean: a later supply fall with no accepted write in between starts no store. A write strobe accepted while idle makes it dirty.
- R11: `standby_ok` is high only when `standby_req` is high and `busy` is low.
- R12: At most one of the four phase strobes is high in any cycle.
- R13: A latched recall takes priority over a software store request presented in the same idle cycle. The store request is then dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| supply_ok | input | 1 | Supply above the switch threshold |
| sw_store_req | input | 1 | Software store request strobe |
| sw_recall_req | input | 1 | Software recall request strobe |
| sram_wr | input | 1 | SRAM write strobe from the access port |
| standby_req | input | 1 | Request to enter low-power standby |
| nv_erase | output | 1 | Store phase 1: erase the nonvolatile array |
| nv_program | output | 1 | Store phase 2: program the nonvolatile array from SRAM |
| sram_clear | output | 1 | Recall phase 1: clear the SRAM array |
| nv_load | output | 1 | Recall phase 2: copy nonvolatile data into SRAM |
| busy | output | 1 | A nonvolatile cycle is active; the SRAM port is blocked |
| standby_ok | output | 1 | Standby may be entered |

## Verification
Several properties are checked on every cycle. At most one phase strobe is ever active. Standby is never granted while busy. Programming is always entered straight from erase. A load is always entered straight from clear, and a clear always hands over to a load, so a recall is never cut short. The bench scenarios cover what depends on history. These are the dirty-flag decision on a supply fall, the phase lengths, the recall latched across a low-supply interval, the store abort, the dropping of requests while busy, and the priority between a pending recall and a software store.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    NVS_IDLE  = 3'd0,
    NVS_ERASE = 3'd1,
    NVS_PROG  = 3'd2,
    NVS_CLEAR = 3'd3,
    NVS_LOAD  = 3'd4
  } nvs_state_e;

  function automatic int nvs_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/nvs_supply_mon.sv
module nvs_supply_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic recall_taken,
  output logic supply_fall,
  output logic recall_pending
);
  logic sup_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sup_q          <= 1'b0;
      recall_pending <= 1'b1;
    end else begin
      sup_q <= supply_ok;
      if (recall_taken)    recall_pending <= 1'b0;
      else if (!supply_ok) recall_pending <= 1'b1;
    end
  end

  assign supply_fall = sup_q & ~supply_ok;
endmodule

// File: rtl/nvs_dirty_flag.sv
module nvs_dirty_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic dirty
);
  always_ff @(posedge clk) begin
    if (!rst_n)    dirty <= 1'b0;
    else if (clr)  dirty <= 1'b0;
    else if (set)  dirty <= 1'b1;
  end
endmodule

// File: rtl/nv_xfer_sequencer.sv
module nv_xfer_sequencer
  import nvs_pkg::*;
#(
  parameter int ERASE_CYC = 1000,
  parameter int PROG_CYC  = 2500,
  parameter int CLEAR_CYC = 40,
  parameter int XFER_CYC  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic sw_store_req,
  input  logic sw_recall_req,
  input  logic sram_wr,
  input  logic standby_req,
  output logic nv_erase,
  output logic nv_program,
  output logic sram_clear,
  output logic nv_load,
  output logic busy,
  output logic standby_ok
);
  localparam int MAXC = nvs_max(nvs_max(ERASE_CYC, PROG_CYC), nvs_max(CLEAR_CYC, XFER_CYC));
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_CYC - 1);
  localparam logic [CW-1:0] PROG_LD  = CW'(PROG_CYC - 1);
  localparam logic [CW-1:0] CLEAR_LD = CW'(CLEAR_CYC - 1);
  localparam logic [CW-1:0] XFER_LD  = CW'(XFER_CYC - 1);

  nvs_state_e st, st_n;
  logic       store_sw, store_sw_n;
  logic       t_load, t_done;
  logic [CW-1:0] t_val;
  logic       recall_take, dirty_clr, dirty_set, dirty;
  logic       sup_fall, rec_pend;

  nvs_phase_timer #(.CW(CW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
  );

  nvs_supply_mon u_supply (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .recall_taken(recall_take),
    .supply_fall(sup_fall), .recall_pending(rec_pend)
  );

  nvs_dirty_flag u_dirty (
    .clk(clk), .rst_n(rst_n), .set(dirty_set), .clr(dirty_clr), .dirty(dirty)
  );

  assign dirty_set = sram_wr & (st == NVS_IDLE);

  always_comb begin
    st_n        = st;
    store_sw_n  = store_sw;
    t_load      = 1'b0;
    t_val       = '0;
    recall_take = 1'b0;
    dirty_clr   = 1'b0;
    unique case (st)
      NVS_IDLE: begin
        if (rec_pend && supply_ok) begin
          st_n = NVS_CLEAR; t_load = 1'b1; t_val = CLEAR_LD; recall_take = 1'b1;
        end else if (sup_fall && dirty) begin
          st_n = NVS_ERASE; t_load = 1'b1; t_val = ERASE_LD; store_sw_n = 1'b0;
        end else if (sw_store_req && supply_ok) begin
          st_n = NVS_ERASE; t_load = 1'b1; t_val = ERASE_LD; store_sw_n = 1'b1;
        end else if (sw_recall_req && supply_ok) begin
          st_n = NVS_CLEAR; t_load = 1'b1; t_val = CLEAR_LD;
        end
      end
      NVS_ERASE: begin
        if (store_sw && !supply_ok) st_n = NVS_IDLE;
        else if (t_done) begin
          st_n = NVS_PROG; t_load = 1'b1; t_val = PROG_LD;
        end
      end
      NVS_PROG: begin
        if (store_sw && !supply_ok) st_n = NVS_IDLE;
        else if (t_done) begin
          st_n = NVS_IDLE; dirty_clr = 1'b1;
        end
      end
      NVS_CLEAR: begin
        if (t_done) begin
          st_n = NVS_LOAD; t_load = 1'b1; t_val = XFER_LD;
        end
      end
      NVS_LOAD: begin
        if (t_done) begin
          st_n = NVS_IDLE; dirty_clr = 1'b1;
        end
      end
      default: st_n = NVS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= NVS_IDLE;
      store_sw <= 1'b0;
    end else begin
      st       <= st_n;
      store_sw <= store_sw_n;
    end
  end

  assign nv_erase   = (st == NVS_ERASE);
  assign nv_program = (st == NVS_PROG);
  assign sram_clear = (st == NVS_CLEAR);
  assign nv_load    = (st == NVS_LOAD);
  assign busy       = (st != NVS_IDLE);
  assign standby_ok = standby_req & ~busy;
endmodule

// File: rtl/nvs_seq_checks.sv
module nvs_seq_checks (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic standby_req,
  input logic nv_erase,
  input logic nv_program,
  input logic sram_clear,
  input logic nv_load,
  input logic busy,
  input logic standby_ok
);
  p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({nv_erase, nv_program, sram_clear, nv_load}));

  p_standby_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    standby_ok |-> (standby_req && !busy));

  p_prog_after_erase_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_program) |-> $past(nv_erase));

  p_erase_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_erase) |-> (nv_program || !busy));

  p_load_after_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_load) |-> $past(sram_clear));

  p_recall_runs_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_clear) |-> nv_load);

  p_busy_has_phase_r12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $countones({nv_erase, nv_program, sram_clear, nv_load}) == 1);
endmodule

bind nv_xfer_sequencer nvs_seq_checks u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .standby_req(standby_req),
  .nv_erase(nv_erase), .nv_program(nv_program), .sram_clear(sram_clear),
  .nv_load(nv_load), .busy(busy), .standby_ok(standby_ok)
);

// File: tb/tb_nv_xfer_sequencer.sv
module tb_nv_xfer_sequencer;
  localparam int EC = 4, PC = 6, CC = 3, XC = 5;

  logic clk = 1'b0;
  logic rst_n, supply_ok, sw_store_req, sw_recall_req, sram_wr, standby_req;
  logic nv_erase, nv_program, sram_clear, nv_load, busy, standby_ok;
  int   checks = 0, fails = 0;
  bit   done_flag = 0;

  always #2 clk = ~clk;

  nv_xfer_sequencer #(.ERASE_CYC(EC), .PROG_CYC(PC), .CLEAR_CYC(CC), .XFER_CYC(XC)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sw_store_req(sw_store_req),
    .sw_recall_req(sw_recall_req), .sram_wr(sram_wr), .standby_req(standby_req),
    .nv_erase(nv_erase), .nv_program(nv_program), .sram_clear(sram_clear),
    .nv_load(nv_load), .busy(busy), .standby_ok(standby_ok)
  );

  // Fields: write, kind (0 sw store, 1 sw recall, 2 supply fall, 3 supply rise),
  // expected erase, program, clear, load cycle counts.
  localparam logic [23:0] VEC [13] = '{
    {4'd0, 4'd0, 4'd4, 4'd6, 4'd0, 4'd0},
    {4'd1, 4'd0, 4'd4, 4'd6, 4'd0, 4'd0},
    {4'd0, 4'd1, 4'd0, 4'd0, 4'd3, 4'd5},
    {4'd1, 4'd2, 4'd4, 4'd6, 4'd0, 4'd0},
    {4'd0, 4'd3, 4'd0, 4'd0, 4'd3, 4'd5},
    {4'd0, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0},
    {4'd0, 4'd3, 4'd0, 4'd0, 4'd3, 4'd5},
    {4'd1, 4'd1, 4'd0, 4'd0, 4'd3, 4'd5},
    {4'd0, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0},
    {4'd0, 4'd3, 4'd0, 4'd0, 4'd3, 4'd5},
    {4'd1, 4'd0, 4'd4, 4'd6, 4'd0, 4'd0},
    {4'd0, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0},
    {4'd0, 4'd3, 4'd0, 4'd0, 4'd3, 4'd5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Entered at a negedge; samples, then steps negedges until the operation ends.
  task automatic observe(output int ce, output int cp, output int cc, output int cl,
                         output bit ord, output bit one);
    bit seen = 0, sp = 0, sl = 0;
    int idle = 0;
    ce = 0; cp = 0; cc = 0; cl = 0; ord = 1; one = 1;
    for (int i = 0; i < 100; i++) begin
      if (busy) seen = 1;
      if ((32'(nv_erase) + 32'(nv_program) + 32'(sram_clear) + 32'(nv_load)) > 1) one = 0;
      if (nv_erase && sp) ord = 0;
      if (sram_clear && sl) ord = 0;
      if (nv_program) sp = 1;
      if (nv_load) sl = 1;
      ce += int'(nv_erase); cp += int'(nv_program);
      cc += int'(sram_clear); cl += int'(nv_load);
      if (!busy) begin
        if (seen) break;
        idle++;
        if (idle >= 4) break;
      end
      @(negedge clk);
    end
  endtask

  task automatic write_once();
    sram_wr = 1'b1; @(negedge clk); sram_wr = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    int ce, cp, cc, cl;
    bit ord, one;
    rst_n = 0; supply_ok = 1; sw_store_req = 0; sw_recall_req = 0;
    sram_wr = 0; standby_req = 0;
    repeat (3) @(negedge clk);
    // Reset state
    chk(!busy && !nv_erase && !nv_program && !sram_clear && !nv_load, "R12 reset", int'(busy), 0);
    rst_n = 1;
    @(negedge clk);
    // R1: power-up recall
    observe(ce, cp, cc, cl, ord, one);
    chk(cc == CC, "R1 clear", cc, CC);
    chk(cl == XC, "R1 load", cl, XC);
    chk(ce + cp == 0, "R1 no store", ce + cp, 0);

    // Vector table
    for (int v = 0; v < 13; v++) begin
      logic [3:0] w, k, ee, ep, ecc, el;
      {w, k, ee, ep, ecc, el} = VEC[v];
      if (w != 0) write_once();
      case (k)
        4'd0: begin sw_store_req = 1; @(negedge clk); sw_store_req = 0; end
        4'd1: begin sw_recall_req = 1; @(negedge clk); sw_recall_req = 0; end
        4'd2: begin supply_ok = 0; @(negedge clk); end
        default: begin supply_ok = 1; @(negedge clk); end
      endcase
      observe(ce, cp, cc, cl, ord, one);
      chk(ce == int'(ee), (k == 2) ? "R2 R10 erase" : "R3 R4 erase", ce, int'(ee));
      chk(cp == int'(ep), "R4 program", cp, int'(ep));
      chk(cc == int'(ecc), (k == 3) ? "R9 clear" : "R5 clear", cc, int'(ecc));
      chk(cl == int'(el), "R5 load", cl, int'(el));
      chk(ord && one, "R12 phase order", int'(ord && one), 1);
    end

    // R6: requests while busy are dropped; R11 standby gated by busy
    standby_req = 1;
    sw_store_req = 1; @(negedge clk); sw_store_req = 0;
    chk(standby_ok == 0, "R11 busy", int'(standby_ok), 0);
    sw_recall_req = 1; @(negedge clk); sw_recall_req = 0;
    observe(ce, cp, cc, cl, ord, one);
    chk(cc + cl == 0, "R6 recall dropped", cc + cl, 0);
    chk(standby_ok == 1, "R11 idle", int'(standby_ok), 1);
    standby_req = 0;
    @(negedge clk);
    observe(ce, cp, cc, cl, ord, one);
    chk(cc + ce == 0, "R6 no late op", cc + ce, 0);

    // R7: software store abandoned on supply drop
    write_once();
    sw_store_req = 1; @(negedge clk); sw_store_req = 0;
    @(negedge clk);
    supply_ok = 0;
    observe(ce, cp, cc, cl, ord, one);
    chk(cp == 0 && ce < EC, "R7 abort", cp, 0);
    @(negedge clk);
    chk(!busy, "R7 idle", int'(busy), 0);
    supply_ok = 1; @(negedge clk);
    observe(ce, cp, cc, cl, ord, one);
    chk(cl == XC, "R9 recall after low", cl, XC);

    // R8: recall survives a supply drop
    sw_recall_req = 1; @(negedge clk); sw_recall_req = 0;
    supply_ok = 0;
    observe(ce, cp, cc, cl, ord, one);
    chk(cc == CC && cl == XC, "R8 full recall", cc + cl, CC + XC);

    // R3: software store ignored while supply low
    @(negedge clk);
    sw_store_req = 1; @(negedge clk); sw_store_req = 0;
    observe(ce, cp, cc, cl, ord, one);
    chk(ce + cp == 0, "R3 inhibit", ce + cp, 0);

    // R13: pending recall wins over a simultaneous store request
    supply_ok = 1; sw_store_req = 1; @(negedge clk); sw_store_req = 0;
    observe(ce, cp, cc, cl, ord, one);
    chk(cc == CC && cl == XC, "R13 recall first", cc + cl, CC + XC);
    chk(ce + cp == 0, "R13 store dropped", ce + cp, 0);
    @(negedge clk);
    observe(ce, cp, cc, cl, ord, one);
    chk(ce == 0, "R13 no late store", ce, 0);

    summary();
  end
endmodule